// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers reset requests from six independent sources and turns them into three internal reset lines: a master reset, a clock-domain reset and an external-pin reset. Each source belongs to one of two timing classes. Asynchronous requests (power-up, watchdog timeout, internal halt) force the lines at once through an async-assert, sync-deassert synchronizer. Synchronous requests (external reset pin, loss of clock reference, test mode) are honoured only at a clock edge where the bus reports idle. This lets an internal byte write or aligned word write that is already under way finish first.

When every request has gone away, the lines stay asserted for a fixed window of `HOLD` clock cycles. At the edge that closes this window the controller captures the mode-select inputs (data bus pins, clock-mode pin, breakpoint pin) and holds them as the operating configuration until the next reset closes. A pin left high selects the default function and a pin pulled low selects the alternate one. A one-hot register reports which source caused the most recent reset.

Top module: `reset_source_ctrl`

## Requirements
- R1: While `rst_n` is low, all three reset lines are high, `cause` is 6'b000001 and every configuration output is 1. After `rst_n` rises between clock edges, the lines stay high through the next `HOLD+1` rising edges and fall at the edge after those.
- R2: A power-up, watchdog or halt request drives `mst_rst`, `clk_rst` and `ext_rst` high with no clock edge needed.
- R3: An external-pin, clock-loss or test request has no effect on the reset lines or on `cause` at any edge where `bus_idle` is low.
- R4: An external-pin or clock-loss request that is sampled with `bus_idle` high raises all three lines at that edge.
- R5: A test-mode request alone raises `mst_rst` and `ext_rst` but leaves `clk_rst` low for the whole reset. `clk_rst` is never high while `mst_rst` is low.
- R6: If the last accepted synchronous request is sampled at edge k, the lines stay high through edge k+HOLD-1 and fall at edge k+HOLD. If the last asynchronous request drops between edges, the lines fall at the (HOLD+2)-th edge after that point.
- R7: `{cfg_bkpt, cfg_clk, cfg_data}` takes the value of `{mode_bkpt, mode_clk, mode_data}` sampled at the edge where the lines fall. The mode inputs have no effect at any other edge.
- R8: `cause` is one-hot with these bits: bit0 power-up, bit1 watchdog, bit2 halt, bit3 external pin, bit4 clock loss, bit5 test. When several requests are accepted at the same edge, the lowest-numbered bit wins.
- R9: `cause` keeps its value after the lines fall and changes only when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the controller |
| pwrup_req | input | 1 | Power-up request, asynchronous |
| wdog_req | input | 1 | Watchdog timeout request, asynchronous |
| halt_req | input | 1 | Internal halt request, asynchronous |
| pin_req | input | 1 | External reset pin request, synchronous |
| clkloss_req | input | 1 | Clock reference loss request, synchronous |
| test_req | input | 1 | Test-mode reset request, synchronous |
| bus_idle | input | 1 | High when no bus write is in progress |
| mode_data | input | DW | Data-bus mode-select pins |
| mode_clk | input | 1 | Clock-mode select pin |
| mode_bkpt | input | 1 | Breakpoint mode select pin |
| mst_rst | output | 1 | Master reset line, active high |
| clk_rst | output | 1 | Clock-domain reset line, active high |
| ext_rst | output | 1 | External-pin reset line, active high |
| cfg_data | output | DW | Captured data-bus configuration |
| cfg_clk | output | 1 | Captured clock-mode configuration |
| cfg_bkpt | output | 1 | Captured breakpoint configuration |
| cause | output | 6 | One-hot cause of the most recent reset |

## Verification
An asynchronous request shows on the lines 1 ns after it is driven, before any edge, and its cause bit appears after the first edge that samples it. A synchronous request shows on the lines and in `cause` 1 ns after the edge where it is sampled with `bus_idle` high. The fall of the lines and the configuration capture come HOLD edges after the last accepted synchronous request, or HOLD+2 edges after an asynchronous request drops. The bench drives every input 1 ns after a rising edge and checks 1 ns after the following edge. It counts edges from the stimulus and checks the lines high on every edge before the expected fall and low on that edge. It moves the mode inputs inside the window to show they are ignored until the closing edge.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int NSRC         = 6;
  localparam int SRC_PWRUP    = 0;
  localparam int SRC_WDOG     = 1;
  localparam int SRC_HALT     = 2;
  localparam int SRC_PIN      = 3;
  localparam int SRC_CLKLOSS  = 4;
  localparam int SRC_TEST     = 5;

  typedef logic [NSRC-1:0] src_vec_t;

  // sources that bypass the bus-idle gate
  localparam src_vec_t ASYNC_SET   = 6'b000111;
  // sources that also drive the clock-domain line
  localparam src_vec_t CLKLINE_SET = 6'b011111;
endpackage

// File: rtl/rsc_arb.sv
module rsc_arb
  import rsc_pkg::*;
(
  input  src_vec_t req_i,
  input  logic     bus_idle_i,
  output src_vec_t pick_o,
  output logic     take_o,
  output logic     async_o,
  output logic     need_clk_o
);
  src_vec_t acc;

  always_comb begin
    // synchronous sources wait for the bus to finish its write
    acc        = (req_i & ASYNC_SET) | (req_i & ~ASYNC_SET & {NSRC{bus_idle_i}});
    // lowest index has highest priority
    pick_o     = acc & (~acc + src_vec_t'(1));
    take_o     = |acc;
    async_o    = |(req_i & ASYNC_SET);
    need_clk_o = |(acc & CLKLINE_SET);
  end
endmodule

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rel_n = sh_q[STAGES-1];
endmodule

// File: rtl/rsc_hold.sv
module rsc_hold #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rel_n,
  input  logic take_i,
  input  logic need_clk_i,
  output logic mst_o,
  output logic clkd_o,
  output logic load_o
);
  localparam int            CW     = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mst_q, mst_d;
  logic          clk_q, clk_d;

  always_comb begin
    cnt_d  = cnt_q;
    mst_d  = mst_q;
    clk_d  = clk_q;
    load_o = 1'b0;
    if (take_i) begin
      mst_d = 1'b1;
      clk_d = clk_q | need_clk_i;
      cnt_d = HOLD_C;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        mst_d  = 1'b0;
        clk_d  = 1'b0;
        load_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rel_n) begin
    if (!rel_n) begin
      cnt_q <= HOLD_C;
      mst_q <= 1'b1;
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      mst_q <= mst_d;
      clk_q <= clk_d;
    end
  end

  assign mst_o  = mst_q;
  assign clkd_o = clk_q;
endmodule

// File: rtl/rsc_cfg.sv
module rsc_cfg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] mode_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q, cfg_d;

  always_comb cfg_d = load_i ? mode_i : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '1;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
  import rsc_pkg::*;
#(
  parameter int DW          = 12,
  parameter int HOLD        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrup_req,
  input  logic          wdog_req,
  input  logic          halt_req,
  input  logic          pin_req,
  input  logic          clkloss_req,
  input  logic          test_req,
  input  logic          bus_idle,
  input  logic [DW-1:0] mode_data,
  input  logic          mode_clk,
  input  logic          mode_bkpt,
  output logic          mst_rst,
  output logic          clk_rst,
  output logic          ext_rst,
  output logic [DW-1:0] cfg_data,
  output logic          cfg_clk,
  output logic          cfg_bkpt,
  output logic [5:0]    cause
);
  localparam int CFGW = DW + 2;

  src_vec_t        req, pick, cause_q, cause_d;
  logic            take, any_async, need_clk, arst_n, rel_n, load;
  logic            mst_w, clk_w;
  logic [CFGW-1:0] cfg_w;

  always_comb begin
    req               = '0;
    req[SRC_PWRUP]    = pwrup_req;
    req[SRC_WDOG]     = wdog_req;
    req[SRC_HALT]     = halt_req;
    req[SRC_PIN]      = pin_req;
    req[SRC_CLKLOSS]  = clkloss_req;
    req[SRC_TEST]     = test_req;
  end

  rsc_arb u_arb (
    .req_i      (req),
    .bus_idle_i (bus_idle),
    .pick_o     (pick),
    .take_o     (take),
    .async_o    (any_async),
    .need_clk_o (need_clk)
  );

  assign arst_n = rst_n & ~any_async;

  rsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rel_n  (rel_n)
  );

  rsc_hold #(.HOLD(HOLD)) u_hold (
    .clk        (clk),
    .rel_n      (rel_n),
    .take_i     (take),
    .need_clk_i (need_clk),
    .mst_o      (mst_w),
    .clkd_o     (clk_w),
    .load_o     (load)
  );

  rsc_cfg #(.W(CFGW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .mode_i ({mode_bkpt, mode_clk, mode_data}),
    .cfg_o  (cfg_w)
  );

  always_comb cause_d = take ? pick : cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= src_vec_t'(1) << SRC_PWRUP;
    else        cause_q <= cause_d;
  end

  assign mst_rst  = mst_w;
  assign ext_rst  = mst_w;
  assign clk_rst  = clk_w;
  assign cfg_data = cfg_w[DW-1:0];
  assign cfg_clk  = cfg_w[DW];
  assign cfg_bkpt = cfg_w[DW+1];
  assign cause    = cause_q;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwrup_req,
  input logic          wdog_req,
  input logic          halt_req,
  input logic          pin_req,
  input logic          clkloss_req,
  input logic          test_req,
  input logic          bus_idle,
  input logic          mst_rst,
  input logic          clk_rst,
  input logic          ext_rst,
  input logic [DW-1:0] cfg_data,
  input logic          cfg_clk,
  input logic          cfg_bkpt,
  input logic [5:0]    cause
);
  logic async_any, sync_any;
  assign async_any = pwrup_req | wdog_req | halt_req;
  assign sync_any  = pin_req | clkloss_req | test_req;

  p_async_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    async_any |-> (mst_rst && clk_rst && ext_rst));

  p_idle_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mst_rst) && !async_any && !$past(async_any)) |-> $past(bus_idle && sync_any));

  p_clk_needs_mst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rst |-> mst_rst);

  p_quiet_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_rst) |-> $past(!async_any && !(sync_any && bus_idle)));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(mst_rst) |-> $stable({cfg_bkpt, cfg_clk, cfg_data}));

  p_cause_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cause) == 1);
endmodule

bind reset_source_ctrl rsc_checker #(.DW(DW)) u_chk (.*);

// File: tb/test_reset_source_ctrl.sv
`timescale 1ns/1ps
module test_reset_source_ctrl;
  localparam int DW   = 12;
  localparam int HOLD = 16;
  localparam int MW   = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    req;
  logic          bus_idle;
  logic [MW-1:0] mode;
  logic          mst_rst, clk_rst, ext_rst, cfg_clk, cfg_bkpt;
  logic [DW-1:0] cfg_data;
  logic [5:0]    cause;

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0]    exp_cause;
  logic [MW-1:0] exp_cfg;

  always #2 clk = ~clk;

  reset_source_ctrl #(.DW(DW), .HOLD(HOLD)) i_reset_source_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pwrup_req(req[0]), .wdog_req(req[1]), .halt_req(req[2]),
    .pin_req(req[3]), .clkloss_req(req[4]), .test_req(req[5]),
    .bus_idle(bus_idle),
    .mode_data(mode[DW-1:0]), .mode_clk(mode[DW]), .mode_bkpt(mode[DW+1]),
    .mst_rst(mst_rst), .clk_rst(clk_rst), .ext_rst(ext_rst),
    .cfg_data(cfg_data), .cfg_clk(cfg_clk), .cfg_bkpt(cfg_bkpt),
    .cause(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [5:0] lowest(input logic [5:0] m);
    return m & (~m + 6'd1);
  endfunction

  function automatic logic [2:0] lines();
    return {mst_rst, clk_rst, ext_rst};
  endfunction

  function automatic logic [MW-1:0] cfg_now();
    return {cfg_bkpt, cfg_clk, cfg_data};
  endfunction

  task automatic episode(input logic [5:0] mask, input int stall, input logic [MW-1:0] m);
    logic       is_async = |(mask & 6'b000111);
    logic [5:0] pick     = lowest(mask);
    logic       want_clk = |(mask & 6'b011111);
    if (is_async) begin
      req = mask;
      #1;
      chk("R2 lines without edge", 32'(lines()), 32'b111);
      tick();
      tick();
      chk("R8 cause async", 32'(cause), 32'(pick));
      req  = '0;
      mode = ~m;
      repeat (HOLD + 1) begin
        tick();
        chk("R6 async window", 32'(mst_rst), 1);
        chk("R7 cfg held in window", 32'(cfg_now()), 32'(exp_cfg));
      end
    end else begin
      bus_idle = 1'b0;
      req      = mask;
      repeat (stall) begin
        tick();
        chk("R3 lines while busy", 32'(lines()), 0);
        chk("R3 cause while busy", 32'(cause), 32'(exp_cause));
      end
      bus_idle = 1'b1;
      tick();
      chk("R4 master/ext on accept", 32'({mst_rst, ext_rst}), 32'b11);
      chk("R5 clock line on accept", 32'(clk_rst), 32'(want_clk));
      chk("R8 cause sync", 32'(cause), 32'(pick));
      req  = '0;
      mode = ~m;
      repeat (HOLD - 1) begin
        tick();
        chk("R6 sync window", 32'({mst_rst, ext_rst}), 32'b11);
        chk("R5 clock line in window", 32'(clk_rst), 32'(want_clk));
        chk("R7 cfg held in window", 32'(cfg_now()), 32'(exp_cfg));
      end
    end
    exp_cause = pick;
    mode = m;
    tick();
    chk("R6 lines released", 32'(lines()), 0);
    exp_cfg = m;
    chk("R7 cfg captured", 32'(cfg_now()), 32'(exp_cfg));
    chk("R9 cause kept", 32'(cause), 32'(exp_cause));
    mode = MW'($urandom);
    tick();
    chk("R7 cfg ignores later mode", 32'(cfg_now()), 32'(exp_cfg));
    chk("R9 cause still kept", 32'(cause), 32'(exp_cause));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n    = 1'b0;
    req      = '0;
    bus_idle = 1'b1;
    mode     = '1;
    #5;
    chk("R1 lines in reset", 32'(lines()), 32'b111);
    chk("R1 cause in reset", 32'(cause), 32'b000001);
    chk("R1 cfg in reset", 32'(cfg_now()), 32'(MW'('1)));
    tick();
    rst_n = 1'b1;
    repeat (HOLD + 1) begin
      tick();
      chk("R1 lines held after release", 32'(lines()), 32'b111);
    end
    tick();
    chk("R1 lines fall", 32'(lines()), 0);
    chk("R1 cfg default", 32'(cfg_now()), 32'(MW'('1)));
    exp_cause = 6'b000001;
    exp_cfg   = '1;

    // directed corners
    episode(6'b100000, 3, MW'(14'h2a5));   // test only, clock line stays low
    episode(6'b001000, 0, MW'(14'h3fff));  // pin, no stall
    episode(6'b001100, 0, MW'(14'h1234));  // halt beats pin
    episode(6'b000011, 0, MW'(14'h0));     // power-up beats watchdog
    episode(6'b110000, 2, MW'(14'h0f0f));  // clock loss beats test

    for (int i = 0; i < 30; i++) begin
      logic [5:0] msk = 6'(1) << ($urandom % 6);
      episode(msk, int'($urandom % 4), MW'($urandom));
      repeat (int'($urandom % 3)) tick();
    end
    finish_run();
  end
endmodule